// File: doc/BRIEF.md
# Performance Counter Enable Filter

This block decides, for one performance counter, whether that counter should count in the current cycle. The caller supplies the counter index, the current privilege level and security state, and a few implementation flags. It also supplies the configuration words that govern counting: the global control word, the counter enable-set word, the hypervisor and monitor debug control words, and the filter word that belongs to the selected counter. Index 31 names the cycle counter. Lower indices name event counters.

The decision combines three terms. The first is a base enable, taken either from the global control or from the hypervisor control, depending on a partition boundary held by the hypervisor. The second is a prohibit term that depends on the security state and the privilege level. The third is a filter term chosen by privilege level from the filter word. A parameter selects whether the one-bit result leaves the block directly or through a flop.

Top module: `pmu_count_gate`

## Requirements
- R1: The boundary HPMN is bits [4:0] of the hypervisor debug control word. The base enable is bit 0 of the global control word when the hypervisor level is absent, or when the index is below HPMN, or when the index is 31. Otherwise the base enable is bit 7 of the hypervisor debug control word.
- R2: A counter is enabled only when its base enable is 1 and bit [index] of the counter enable-set word is 1.
- R3: In non-secure state at privilege level 2, a counter whose index is below HPMN, or the cycle counter, is prohibited when bit 17 of the hypervisor debug control word is 1.
- R4: In non-secure state, every other combination of level and index is never prohibited.
- R5: In secure state, a counter is prohibited when the monitor level is present and bit 17 of the monitor debug control word is 0. In secure state with no monitor level, a counter is not prohibited.
- R6: When the cycle counter (index 31) would be prohibited, bit 4 of the global control word decides instead: 1 means prohibited, 0 means not prohibited.
- R7: The filter word fields are P=bit 31, U=bit 30, NSK=bit 29, NSU=bit 28, NSH=bit 27 and M=bit 26. NSK and NSU read as 0 without the monitor level. NSH reads as 0 without the hypervisor level. M reads as 0 unless the monitor level is present and privilege level 1 is 64-bit.
- R8: The filter applies when U is set at level 0 in secure state, and when U differs from NSU at level 0 in non-secure state. At level 1 it applies when P is set in secure state, and when P differs from NSK in non-secure state.
- R9: The filter applies when NSH is 0 at level 2, and when M differs from P at level 3.
- R10: The output is 1 exactly when the counter is enabled, not prohibited and not filtered. With REG_OUT=1 the output follows the inputs one clock edge later. With REG_OUT=0 it follows them in the same cycle.
- R11: With REG_OUT=1, an active-low reset forces the output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered output |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctr_idx_i | input | 5 | Counter index, where 31 is the cycle counter |
| priv_lvl_i | input | 2 | Current privilege level, 0 to 3 |
| secure_i | input | 1 | Secure state |
| has_hyp_i | input | 1 | The hypervisor level is implemented |
| has_mon_i | input | 1 | The monitor level is implemented |
| el1_64_i | input | 1 | Privilege level 1 is 64-bit |
| glb_ctrl_i | input | 32 | Global control word |
| cnt_en_set_i | input | 32 | Counter enable-set word |
| hyp_dbg_i | input | 32 | Hypervisor debug control word |
| mon_dbg_i | input | 32 | Monitor debug control word |
| filt_word_i | input | 32 | Filter word of the selected counter |
| count_en_o | output | 1 | Count enable for this cycle |

## Verification
The bench builds two instances. One uses the default REG_OUT=1, which brings the reset value and the one-edge latency within reach. The other uses REG_OUT=0, so that each input pattern can be checked in the same cycle. Both instances keep the 5-bit index and the 32-bit words, so the bench can reach index 31 and choose the HPMN boundary freely, including values below, equal to and above the index. The two implementation flags are varied with the privilege levels, which exercises every masking rule of the filter fields.

// File: rtl/pmu_filt_pkg.sv
package pmu_filt_pkg;
  localparam int unsigned GLB_EN_BIT   = 0;
  localparam int unsigned GLB_DP_BIT   = 4;
  localparam int unsigned HYP_EN_BIT   = 7;
  localparam int unsigned HYP_PROH_BIT = 17;
  localparam int unsigned MON_PERM_BIT = 17;
  localparam int unsigned FLT_P   = 31;
  localparam int unsigned FLT_U   = 30;
  localparam int unsigned FLT_NSK = 29;
  localparam int unsigned FLT_NSU = 28;
  localparam int unsigned FLT_NSH = 27;
  localparam int unsigned FLT_M   = 26;
endpackage

// File: rtl/pcf_enable.sv
module pcf_enable
  import pmu_filt_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CYC_IDX = 31
) (
  input  logic [IDX_W-1:0]  ctr_idx_i,
  input  logic              has_hyp_i,
  input  logic [WORD_W-1:0] glb_ctrl_i,
  input  logic [WORD_W-1:0] cnt_en_set_i,
  input  logic [WORD_W-1:0] hyp_dbg_i,
  output logic              low_part_o,
  output logic              is_cyc_o,
  output logic              enabled_o
);
  logic [IDX_W-1:0] hpmn;
  logic             base_en;

  assign hpmn       = hyp_dbg_i[IDX_W-1:0];
  assign is_cyc_o   = (ctr_idx_i == IDX_W'(CYC_IDX));
  assign low_part_o = (ctr_idx_i < hpmn) || is_cyc_o;

  always_comb begin
    if (!has_hyp_i || low_part_o) base_en = glb_ctrl_i[GLB_EN_BIT];
    else                          base_en = hyp_dbg_i[HYP_EN_BIT];
  end

  assign enabled_o = base_en && cnt_en_set_i[ctr_idx_i];
endmodule

// File: rtl/pcf_prohibit.sv
module pcf_prohibit
  import pmu_filt_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              secure_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              has_mon_i,
  input  logic              low_part_i,
  input  logic              is_cyc_i,
  input  logic [WORD_W-1:0] glb_ctrl_i,
  input  logic [WORD_W-1:0] hyp_dbg_i,
  input  logic [WORD_W-1:0] mon_dbg_i,
  output logic              prohibited_o
);
  logic raw;

  always_comb begin
    if (secure_i)
      raw = has_mon_i && !mon_dbg_i[MON_PERM_BIT];
    else if (priv_lvl_i == 2'd2 && low_part_i)
      raw = hyp_dbg_i[HYP_PROH_BIT];
    else
      raw = 1'b0;
  end

  // cycle counter: prohibition is gated by the disable-when-prohibited bit
  assign prohibited_o = raw && (!is_cyc_i || glb_ctrl_i[GLB_DP_BIT]);
endmodule

// File: rtl/pcf_filter.sv
module pcf_filter
  import pmu_filt_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              secure_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              has_hyp_i,
  input  logic              has_mon_i,
  input  logic              el1_64_i,
  input  logic [WORD_W-1:0] filt_word_i,
  output logic              filtered_o
);
  logic f_p, f_u, f_nsk, f_nsu, f_nsh, f_m;

  assign f_p   = filt_word_i[FLT_P];
  assign f_u   = filt_word_i[FLT_U];
  assign f_nsk = has_mon_i && filt_word_i[FLT_NSK];
  assign f_nsu = has_mon_i && filt_word_i[FLT_NSU];
  assign f_nsh = has_hyp_i && filt_word_i[FLT_NSH];
  assign f_m   = has_mon_i && el1_64_i && filt_word_i[FLT_M];

  always_comb begin
    unique case (priv_lvl_i)
      2'd0:    filtered_o = secure_i ? f_u : (f_u ^ f_nsu);
      2'd1:    filtered_o = secure_i ? f_p : (f_p ^ f_nsk);
      2'd2:    filtered_o = !f_nsh;
      default: filtered_o = f_m ^ f_p;
    endcase
  end
endmodule

// File: rtl/pmu_count_gate.sv
module pmu_count_gate
  import pmu_filt_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned CYC_IDX = 31,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ctr_idx_i,
  input  logic [1:0]        priv_lvl_i,
  input  logic              secure_i,
  input  logic              has_hyp_i,
  input  logic              has_mon_i,
  input  logic              el1_64_i,
  input  logic [WORD_W-1:0] glb_ctrl_i,
  input  logic [WORD_W-1:0] cnt_en_set_i,
  input  logic [WORD_W-1:0] hyp_dbg_i,
  input  logic [WORD_W-1:0] mon_dbg_i,
  input  logic [WORD_W-1:0] filt_word_i,
  output logic              count_en_o
);
  logic low_part, is_cyc, enabled, prohibited, filtered, decide;

  pcf_enable #(.IDX_W(IDX_W), .WORD_W(WORD_W), .CYC_IDX(CYC_IDX)) u_enable (
    .ctr_idx_i    (ctr_idx_i),
    .has_hyp_i    (has_hyp_i),
    .glb_ctrl_i   (glb_ctrl_i),
    .cnt_en_set_i (cnt_en_set_i),
    .hyp_dbg_i    (hyp_dbg_i),
    .low_part_o   (low_part),
    .is_cyc_o     (is_cyc),
    .enabled_o    (enabled)
  );

  pcf_prohibit #(.WORD_W(WORD_W)) u_prohibit (
    .secure_i     (secure_i),
    .priv_lvl_i   (priv_lvl_i),
    .has_mon_i    (has_mon_i),
    .low_part_i   (low_part),
    .is_cyc_i     (is_cyc),
    .glb_ctrl_i   (glb_ctrl_i),
    .hyp_dbg_i    (hyp_dbg_i),
    .mon_dbg_i    (mon_dbg_i),
    .prohibited_o (prohibited)
  );

  pcf_filter #(.WORD_W(WORD_W)) u_filter (
    .secure_i    (secure_i),
    .priv_lvl_i  (priv_lvl_i),
    .has_hyp_i   (has_hyp_i),
    .has_mon_i   (has_mon_i),
    .el1_64_i    (el1_64_i),
    .filt_word_i (filt_word_i),
    .filtered_o  (filtered)
  );

  assign decide = enabled && !prohibited && !filtered;

  generate
    if (REG_OUT) begin : g_reg
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= decide;
      end
      assign count_en_o = q;
    end else begin : g_comb
      assign count_en_o = decide;
    end
  endgenerate
endmodule

// File: rtl/pmu_count_gate_chk.sv
module pmu_count_gate_chk #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned WORD_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  ctr_idx_i,
  input logic [1:0]        priv_lvl_i,
  input logic              secure_i,
  input logic              has_hyp_i,
  input logic              has_mon_i,
  input logic              el1_64_i,
  input logic [WORD_W-1:0] glb_ctrl_i,
  input logic [WORD_W-1:0] cnt_en_set_i,
  input logic [WORD_W-1:0] hyp_dbg_i,
  input logic [WORD_W-1:0] mon_dbg_i,
  input logic [WORD_W-1:0] filt_word_i,
  input logic              count_en_o
);
  logic no_set_bit, cyc_glb_off, l2_nsh_off, sec_block;

  assign no_set_bit  = !cnt_en_set_i[ctr_idx_i];
  assign cyc_glb_off = (ctr_idx_i == '1) && !glb_ctrl_i[0];
  assign l2_nsh_off  = (priv_lvl_i == 2'd2) && !(has_hyp_i && filt_word_i[27]);
  assign sec_block   = secure_i && has_mon_i && !mon_dbg_i[17] && (ctr_idx_i != '1);

  generate
    if (REG_OUT) begin : g_reg
      a_r2_no_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_set_bit |=> !count_en_o);
      a_r1_cyc_glb_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_glb_off |=> !count_en_o);
      a_r9_l2_filtered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        l2_nsh_off |=> !count_en_o);
      a_r5_secure_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_block |=> !count_en_o);
      always @(posedge clk_i) begin
        if (!rst_ni) a_r11_reset_low: assert (!count_en_o);
      end
    end else begin : g_comb
      a_r2_no_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_set_bit |-> !count_en_o);
      a_r1_cyc_glb_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_glb_off |-> !count_en_o);
      a_r9_l2_filtered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        l2_nsh_off |-> !count_en_o);
      a_r5_secure_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_block |-> !count_en_o);
    end
  endgenerate
endmodule

bind pmu_count_gate pmu_count_gate_chk #(.IDX_W(IDX_W), .WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/pmu_count_gate_bench.sv
module pmu_count_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  idx = '0;
  logic [1:0]  lvl = '0;
  logic        sec = 1'b0, hyp = 1'b0, mon = 1'b0, e64 = 1'b0;
  logic [31:0] glb = '0, ens = '0, hdc = '0, mdc = '0, flt = '0;
  logic        out_r, out_c;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  pmu_count_gate u_pmu_count_gate (
    .clk_i(clk), .rst_ni(rst_n), .ctr_idx_i(idx), .priv_lvl_i(lvl), .secure_i(sec),
    .has_hyp_i(hyp), .has_mon_i(mon), .el1_64_i(e64), .glb_ctrl_i(glb),
    .cnt_en_set_i(ens), .hyp_dbg_i(hdc), .mon_dbg_i(mdc), .filt_word_i(flt),
    .count_en_o(out_r));

  pmu_count_gate #(.REG_OUT(1'b0)) u_pmu_count_gate_comb (
    .clk_i(clk), .rst_ni(rst_n), .ctr_idx_i(idx), .priv_lvl_i(lvl), .secure_i(sec),
    .has_hyp_i(hyp), .has_mon_i(mon), .el1_64_i(e64), .glb_ctrl_i(glb),
    .cnt_en_set_i(ens), .hyp_dbg_i(hdc), .mon_dbg_i(mdc), .filt_word_i(flt),
    .count_en_o(out_c));

  function automatic bit ref_model();
    bit first, base, en, proh, fl;
    bit p, u, nsk, nsu, nsh, m;
    first = (idx < hdc[4:0]) || (idx == 5'd31);
    base  = (!hyp || first) ? glb[0] : hdc[7];
    en    = base && ens[idx];
    if (sec)                      proh = mon && !mdc[17];
    else if (lvl == 2 && first)   proh = hdc[17];
    else                          proh = 1'b0;
    if (proh && idx == 5'd31) proh = glb[4];
    p = flt[31]; u = flt[30];
    nsk = mon && flt[29]; nsu = mon && flt[28];
    nsh = hyp && flt[27]; m = mon && e64 && flt[26];
    case (lvl)
      2'd0: fl = sec ? u : (u != nsu);
      2'd1: fl = sec ? p : (p != nsk);
      2'd2: fl = !nsh;
      default: fl = (m != p);
    endcase
    return en && !proh && !fl;
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // inputs are set at a negedge; comb checked at once, registered after next posedge
  task automatic apply(string req);
    bit e;
    #1;
    e = ref_model();
    check({req, " comb"}, out_c, e);
    @(posedge clk); #1;
    check({req, " reg"}, out_r, e);
    @(negedge clk);
  endtask

  task automatic base_cfg();
    idx = 5'd31; lvl = 2'd1; sec = 1'b0; hyp = 1'b1; mon = 1'b1; e64 = 1'b1;
    glb = 32'h1; ens = 32'hFFFF_FFFF; hdc = 32'h0000_0008; mdc = 32'h0002_0000;
    flt = 32'h0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    base_cfg();
    glb = 32'h1;
    repeat (3) @(negedge clk);
    check("R11 reset", out_r, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 base enable selection
    base_cfg(); apply("R1 cyc counts");
    base_cfg(); idx = 5'd31; glb = 32'h0; hdc = 32'h88; apply("R1 cyc ignores hyp en");
    base_cfg(); idx = 5'd3; hdc = 32'h8; glb = 32'h0; apply("R1 below hpmn glb off");
    base_cfg(); idx = 5'd10; hdc = 32'h88; glb = 32'h0; apply("R1 above hpmn hyp en");
    base_cfg(); idx = 5'd8; hdc = 32'h08; glb = 32'h1; apply("R1 at hpmn hyp off");
    base_cfg(); idx = 5'd10; hyp = 1'b0; hdc = 32'h08; apply("R1 no hyp glb");
    // R2 enable-set bit
    base_cfg(); idx = 5'd2; ens = 32'hFFFF_FFFB; apply("R2 set bit clear");
    base_cfg(); idx = 5'd31; ens = 32'h7FFF_FFFF; apply("R2 cyc bit clear");
    // R3/R4 non-secure prohibit
    base_cfg(); lvl = 2'd2; flt = 32'h0800_0000; idx = 5'd1; hdc = 32'h0002_0008; apply("R3 l2 low prohibited");
    base_cfg(); lvl = 2'd2; flt = 32'h0800_0000; idx = 5'd12; hdc = 32'h0002_0088; apply("R4 l2 high not prohibited");
    base_cfg(); lvl = 2'd1; idx = 5'd1; hdc = 32'h0002_0008; apply("R4 l1 not prohibited");
    // R5 secure
    base_cfg(); sec = 1'b1; idx = 5'd4; mdc = 32'h0; apply("R5 secure no perm");
    base_cfg(); sec = 1'b1; idx = 5'd4; mdc = 32'h0; mon = 1'b0; apply("R5 secure no monitor");
    base_cfg(); sec = 1'b1; idx = 5'd4; apply("R5 secure permitted");
    // R6 cycle counter override
    base_cfg(); sec = 1'b1; mdc = 32'h0; glb = 32'h01; apply("R6 cyc dp clear");
    base_cfg(); sec = 1'b1; mdc = 32'h0; glb = 32'h11; apply("R6 cyc dp set");
    base_cfg(); lvl = 2'd2; flt = 32'h0800_0000; hdc = 32'h0002_0008; glb = 32'h11; apply("R6 cyc l2 dp set");
    // R7 masking
    base_cfg(); lvl = 2'd0; flt = 32'h5000_0000; apply("R7 nsu matches u");
    base_cfg(); lvl = 2'd0; flt = 32'h5000_0000; mon = 1'b0; apply("R7 nsu masked no mon");
    base_cfg(); lvl = 2'd3; flt = 32'h8400_0000; apply("R7 m with mon 64");
    base_cfg(); lvl = 2'd3; flt = 32'h8400_0000; e64 = 1'b0; apply("R7 m masked 32");
    base_cfg(); lvl = 2'd2; flt = 32'h0800_0000; hyp = 1'b0; apply("R7 nsh masked no hyp");
    // R8 / R9 filters
    base_cfg(); lvl = 2'd0; sec = 1'b1; flt = 32'h4000_0000; apply("R8 l0 secure u");
    base_cfg(); lvl = 2'd1; flt = 32'h8000_0000; apply("R8 l1 p no nsk");
    base_cfg(); lvl = 2'd1; flt = 32'hA000_0000; apply("R8 l1 p with nsk");
    base_cfg(); lvl = 2'd2; flt = 32'h0; apply("R9 l2 no nsh");
    base_cfg(); lvl = 2'd3; flt = 32'h8000_0000; apply("R9 l3 p only");

    // R10 random combinations
    for (int i = 0; i < 400; i++) begin
      idx = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
      lvl = 2'($urandom); sec = 1'($urandom);
      hyp = 1'($urandom); mon = 1'($urandom); e64 = 1'($urandom);
      glb = $urandom; ens = $urandom | 32'h8000_0001;
      hdc = $urandom; mdc = $urandom; flt = $urandom;
      apply("R10 random");
    end

    rst_n = 1'b0; #1;
    check("R11 reset again", out_r, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule